// File: doc/BRIEF.md
# Verified Scratchpad Write/Readback Controller

This block is a byte-level command engine sitting in front of an eight-byte staging buffer. The buffer holds data until a later step copies it into main memory. A host opens each transaction with a transaction-reset strobe. It then streams bytes in, and each byte comes with the number of bits that actually arrived.

A write transaction loads a target address and eight data bytes. The engine can then answer with an inverted CRC16 of everything it received. A read transaction returns the stored address, a transfer-status byte and the buffer contents, closed by an inverted CRC16 of everything in that transaction.

The status byte carries two flags. The first marks the buffer contents as untrustworthy. This happens after power-up, after a truncated byte, or after a write that stopped early. The second records that a copy of the buffer into memory has completed. The host uses the echo, the flags and both checksums to confirm a write before it asks for the copy.

Top module: `spad_ctrl`

## Requirements
- R1: After reset the status byte reads 0x7F (partial flag set, copy flag clear), both address registers read 0x00 and tx_valid is low.
- R2: The low address byte is stored with bits 2..0 forced to zero (0x3D is held and echoed as 0x38). The high address byte is stored unchanged.
- R3: Status bits 6, 4, 3, 2, 1 and 0 always read 1. Bit 5 is the partial flag and bit 7 is the copy-accepted flag.
- R4: After txn_rst, the command 0x0F, two address bytes (low first) and eight full data bytes store the data at offsets 0..7 in arrival order. The eighth full byte clears the partial flag.
- R5: After the eighth data byte, tx_valid rises and the engine offers the inverted CRC16 low byte, then the high byte, one per tx_pop. The CRC covers the command, the address bytes as received (before forcing) and the data. It uses polynomial x^16+x^15+x^2+1, a zero start value, and processes each byte LSB first.
- R6: After txn_rst, command 0xAA offers, one per tx_pop, the following bytes: low address, high address, status, data offsets 0..7, and then the inverted CRC16 (low byte first) over the command and those eleven bytes.
- R7: During a write, a byte with rx_bits other than 8 sets the partial flag, is not stored and ends the transaction.
- R8: A txn_rst after the write command but before the eighth data byte sets the partial flag. Data bytes already received stay at their offsets.
- R9: A copy_done pulse sets the copy-accepted flag only when the partial flag is clear and no write is in progress. Otherwise it has no effect.
- R10: Any command byte other than 0x0F or 0xAA is ignored. No output is offered and later bytes change nothing until the next txn_rst.
- R11: Accepting the write command 0x0F clears the copy-accepted flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| txn_rst | input | 1 | Starts a new transaction; the next byte is a command |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_bits | input | 4 | Number of bits received in rx_byte (8 = complete) |
| copy_done | input | 1 | Pulse: buffer copied to memory |
| tx_pop | input | 1 | Host consumes the offered transmit byte |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_byte | output | 8 | Offered transmit byte |
| addr_lo | output | 8 | Stored low target address (bits 2..0 zero) |
| addr_hi | output | 8 | Stored high target address |
| status | output | 8 | Transfer-status byte |

## Verification
The write path is tried with a misaligned low address and a patterned data set. This separates the raw address that feeds the checksum from the forced address that is stored and echoed.

A readback after a copy pulse shows that the status byte is sampled into the read checksum with both flags in their final state. Writes that stop early, either through a transaction reset or a short byte, are each followed by a readback. That readback shows which offsets kept new data and which kept old.

A copy pulse during a write and another with the partial flag set tell gated from ungated copy handling. An unknown command followed by address-like bytes shows that the engine stays silent.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADR0, ST_ADR1, ST_WDAT, ST_WCRC, ST_RD
  } spad_st_e;

  localparam logic [7:0]  OP_WRITE  = 8'h0F;
  localparam logic [7:0]  OP_READ   = 8'hAA;
  localparam logic [15:0] CRC_POLY  = 16'hA001;  // reflected x^16+x^15+x^2+1

  // One byte through the reflected CRC16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/spad_store.sv
module spad_store #(
  parameter int NBYTES = 8,
  localparam int IDXW = $clog2(NBYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_data
);
  logic [7:0] cells [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cells[g] <= 8'h00;
      else if (wr_en && wr_idx == IDXW'(g))        cells[g] <= wr_data;
    end
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/spad_status.sv
module spad_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_start,
  input  logic       wr_done,
  input  logic       wr_abort,
  input  logic       wr_busy,
  input  logic       copy_done,
  output logic       pf,
  output logic       aa,
  output logic [7:0] status
);
  logic copy_ok;
  assign copy_ok = copy_done && !pf && !wr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf <= 1'b1;
      aa <= 1'b0;
    end else begin
      if (wr_abort)     pf <= 1'b1;
      else if (wr_done) pf <= 1'b0;
      if (wr_start)     aa <= 1'b0;
      else if (copy_ok) aa <= 1'b1;
    end
  end

  assign status = {aa, 1'b1, pf, 5'b11111};

  p_abort_sets_pf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> pf);
  p_done_clears_pf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done && !wr_abort |=> !pf);
  p_start_clears_aa_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !aa);
  p_pf_excludes_aa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf |-> !aa);
  p_copy_sets_aa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done && !pf && !wr_busy && !wr_start |=> aa);
endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int ALIGN  = 3,
  localparam int IDXW = $clog2(NBYTES),
  localparam int CNTW = $clog2(NBYTES + 5)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic [3:0] rx_bits,
  input  logic       copy_done,
  input  logic       tx_pop,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic [7:0] addr_lo,
  output logic [7:0] addr_hi,
  output logic [7:0] status
);
  localparam logic [7:0] ALIGN_MASK = ~8'((1 << ALIGN) - 1);
  localparam logic [CNTW-1:0] LAST_DAT = CNTW'(NBYTES - 1);
  localparam logic [CNTW-1:0] RD_CRC0  = CNTW'(NBYTES + 3);
  localparam logic [CNTW-1:0] RD_CRC1  = CNTW'(NBYTES + 4);

  spad_st_e        st;
  logic [CNTW-1:0] idx;
  logic [15:0]     crc;
  logic            pf, aa;
  logic [7:0]      rd_data;
  logic [CNTW-1:0] rd_off;

  // Named events used by the flag logic and by the assertions.
  logic rx_take, rx_full, rx_short, in_wr, tx_take;
  logic evt_wr_start, evt_data, evt_wr_done, evt_abort, evt_bad_cmd;

  assign rx_take      = rx_valid && !txn_rst;
  assign rx_full      = rx_take && rx_bits == 4'd8;
  assign rx_short     = rx_take && rx_bits != 4'd8;
  assign in_wr        = st == ST_ADR0 || st == ST_ADR1 || st == ST_WDAT;
  assign tx_take      = tx_valid && tx_pop && !txn_rst;
  assign evt_wr_start = st == ST_CMD && rx_full && rx_byte == OP_WRITE;
  assign evt_bad_cmd  = st == ST_CMD && rx_take && !(rx_full && (rx_byte == OP_WRITE || rx_byte == OP_READ));
  assign evt_data     = st == ST_WDAT && rx_full;
  assign evt_wr_done  = evt_data && idx == LAST_DAT;
  assign evt_abort    = in_wr && (txn_rst || rx_short);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      crc     <= '0;
      addr_lo <= '0;
      addr_hi <= '0;
    end else if (txn_rst) begin
      st  <= ST_CMD;
      idx <= '0;
      crc <= '0;
    end else begin
      unique case (st)
        ST_CMD: if (rx_valid) begin
          if (rx_full && rx_byte == OP_WRITE) begin
            st  <= ST_ADR0;
            crc <= crc16_step(crc, rx_byte);
          end else if (rx_full && rx_byte == OP_READ) begin
            st  <= ST_RD;
            idx <= '0;
            crc <= crc16_step(crc, rx_byte);
          end else st <= ST_IDLE;
        end
        ST_ADR0: if (rx_full) begin
          addr_lo <= rx_byte & ALIGN_MASK;
          crc     <= crc16_step(crc, rx_byte);
          st      <= ST_ADR1;
        end else if (rx_short) st <= ST_IDLE;
        ST_ADR1: if (rx_full) begin
          addr_hi <= rx_byte;
          crc     <= crc16_step(crc, rx_byte);
          idx     <= '0;
          st      <= ST_WDAT;
        end else if (rx_short) st <= ST_IDLE;
        ST_WDAT: if (rx_full) begin
          crc <= crc16_step(crc, rx_byte);
          if (idx == LAST_DAT) begin
            idx <= '0;
            st  <= ST_WCRC;
          end else idx <= idx + 1'b1;
        end else if (rx_short) st <= ST_IDLE;
        ST_WCRC: if (tx_take) begin
          if (idx != '0) st <= ST_IDLE;
          else           idx <= CNTW'(1);
        end
        ST_RD: if (tx_take) begin
          if (idx < RD_CRC0) crc <= crc16_step(crc, tx_byte);
          if (idx == RD_CRC1) st <= ST_IDLE;
          else                idx <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rd_off = idx - CNTW'(3);

  always_comb begin
    tx_valid = st == ST_WCRC || st == ST_RD;
    tx_byte  = 8'h00;
    if (st == ST_WCRC) tx_byte = (idx == '0) ? ~crc[7:0] : ~crc[15:8];
    else if (st == ST_RD) begin
      if      (idx == CNTW'(0)) tx_byte = addr_lo;
      else if (idx == CNTW'(1)) tx_byte = addr_hi;
      else if (idx == CNTW'(2)) tx_byte = status;
      else if (idx < RD_CRC0)   tx_byte = rd_data;
      else if (idx == RD_CRC0)  tx_byte = ~crc[7:0];
      else                      tx_byte = ~crc[15:8];
    end
  end

  spad_store #(.NBYTES(NBYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(evt_data), .wr_idx(idx[IDXW-1:0]), .wr_data(rx_byte),
    .rd_idx(rd_off[IDXW-1:0]), .rd_data(rd_data)
  );

  spad_status u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_start(evt_wr_start), .wr_done(evt_wr_done), .wr_abort(evt_abort),
    .wr_busy(in_wr), .copy_done(copy_done),
    .pf(pf), .aa(aa), .status(status)
  );

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ADR0 && rx_full |=> addr_lo[ALIGN-1:0] == '0);
  p_crc_offered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_done |=> tx_valid);
  p_bad_cmd_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bad_cmd |=> !tx_valid && $stable(addr_lo) && $stable(addr_hi));
  p_short_ends_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr && rx_short |=> !tx_valid && pf);
endmodule

// File: tb/tb_spad_ctrl.sv
module tb_spad_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_rst = 1'b0, rx_valid = 1'b0, copy_done = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [3:0] rx_bits = 4'd8;
  logic tx_valid;
  logic [7:0] tx_byte, addr_lo, addr_hi, status;
  int n_chk = 0, n_bad = 0;

  logic [7:0] mem [8];   // expected buffer contents

  always #2 clk = ~clk;

  spad_ctrl dut (.*);

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] s;
    logic fb;
    s = c;
    for (int b = 0; b < 8; b++) begin
      fb = s[0] ^ d[b];
      s  = {1'b0, s[15:1]};
      if (fb) s = s ^ 16'hA001;
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic txn();
    @(negedge clk); txn_rst = 1'b1;
    @(negedge clk); txn_rst = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic [3:0] n = 4'd8);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_bits = n;
    @(negedge clk); rx_valid = 1'b0; rx_bits = 4'd8;
  endtask

  task automatic copy_pulse();
    @(negedge clk); copy_done = 1'b1;
    @(negedge clk); copy_done = 1'b0;
  endtask

  task automatic pop(input string tag, input logic [7:0] exp);
    chk({tag, " valid"}, {7'd0, tx_valid}, 8'h01);
    chk(tag, tx_byte, exp);
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h7F);
    chk("R1 addr_lo", addr_lo, 8'h00);
    chk("R1 addr_hi", addr_hi, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_full_write(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] seed);
    logic [15:0] c;
    txn();
    rx(8'h0F); c = ref_crc(16'h0, 8'h0F);
    rx(lo);    c = ref_crc(c, lo);
    rx(hi);    c = ref_crc(c, hi);
    for (int i = 0; i < 8; i++) begin
      mem[i] = seed + 8'(i * 17);
      rx(mem[i]); c = ref_crc(c, mem[i]);
    end
    chk("R2 addr_lo forced", addr_lo, lo & 8'hF8);
    chk("R2 addr_hi", addr_hi, hi);
    chk("R4 status after write", status, 8'h5F);
    pop("R5 crc lo", ~c[7:0]);
    pop("R5 crc hi", ~c[15:8]);
    chk("R5 done", {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_read(input string tag);
    logic [15:0] c;
    logic [7:0] st_v, lo_v, hi_v;
    st_v = status; lo_v = addr_lo; hi_v = addr_hi;
    txn();
    rx(8'hAA); c = ref_crc(16'h0, 8'hAA);
    pop({tag, " R6 lo"}, lo_v); c = ref_crc(c, lo_v);
    pop({tag, " R6 hi"}, hi_v); c = ref_crc(c, hi_v);
    pop({tag, " R3 status"}, st_v); c = ref_crc(c, st_v);
    for (int i = 0; i < 8; i++) begin
      pop({tag, " R6 data"}, mem[i]); c = ref_crc(c, mem[i]);
    end
    pop({tag, " R6 crc lo"}, ~c[7:0]);
    pop({tag, " R6 crc hi"}, ~c[15:8]);
  endtask

  task automatic t_copy_and_read();
    copy_pulse();
    chk("R9 copy accepted", status, 8'hDF);
    t_read("copied");
  endtask

  task automatic t_abort();
    txn();
    rx(8'h0F);
    chk("R11 aa cleared", status, 8'h5F);
    rx(8'h40); rx(8'h01);
    for (int i = 0; i < 3; i++) begin
      mem[i] = 8'hC0 + 8'(i);
      rx(mem[i]);
    end
    copy_pulse();
    chk("R9 copy ignored mid-write", status, 8'h5F);
    txn();
    chk("R8 abort sets pf", status, 8'h7F);
    copy_pulse();
    chk("R9 copy ignored with pf", status, 8'h7F);
    t_read("aborted R8");
  endtask

  task automatic t_partial();
    t_full_write(8'h10, 8'h22, 8'h05);
    txn();
    rx(8'h0F); rx(8'h10); rx(8'h22);
    mem[0] = 8'h99; rx(mem[0]);
    rx(8'h77, 4'd5);
    chk("R7 pf set", status, 8'h7F);
    chk("R7 no tx", {7'd0, tx_valid}, 8'h00);
    rx(8'h66);
    t_read("partial R7");
  endtask

  task automatic t_bad_cmd();
    logic [7:0] lo_v, hi_v, st_v;
    lo_v = addr_lo; hi_v = addr_hi; st_v = status;
    txn();
    rx(8'h55); rx(8'h0F); rx(8'hF0); rx(8'hAB);
    chk("R10 no tx", {7'd0, tx_valid}, 8'h00);
    chk("R10 addr_lo kept", addr_lo, lo_v);
    chk("R10 addr_hi kept", addr_hi, hi_v);
    chk("R10 status kept", status, st_v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write(8'h3D, 8'h12, 8'h31);
    t_copy_and_read();
    t_abort();
    t_partial();
    t_bad_cmd();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule